// File: doc/BRIEF.md
# Tapered-Window Bitstream Filter

This block filters the one-bit output of a delta-sigma converter with a fixed 45-point tapered window. The window is flat in the middle and has raised-cosine-like edges. One converter bit enters per clock. The block keeps the last 45 bits and produces a new unsigned sample on every clock. That sample is the sum of the window weights at every position that holds a 1. The window weights add up to 1024, so a stream of all ones reads full scale.

The block does not add up 45 weighted taps each cycle. It keeps the sample in a running register and corrects it once per clock. The slope of the window is constant over a few short runs of taps, so the correction is a small signed sum: each run's population of ones is scaled by that run's slope (plus or minus 1, 2 or 3), and the incoming bit is added with weight 1. The result stays equal to the direct weighted sum at every cycle. A valid flag shows when the history is completely filled with real bits. A synchronous clear restarts the filter from an empty history.

Top module: `tukey_bitstream_filter`

## Requirements
- R1: While `rst_ni` is low, `sample_o` is 0 and `valid_o` is 0.
- R2: Suppose a single 1 was sampled k clocks before the latest one and every other bit in the history is 0. Then `sample_o` equals weight w(k). For k = 0..13 the weights are 1, 3, 5, 7, 10, 13, 16, 19, 22, 25, 27, 29, 31, 32. For k = 13..31 the weight is 32. For k = 32..44 the weight is w(44-k). For k above 44 the weight is 0.
- R3: `sample_o` always equals the sum of w(k) over the bit sampled k clocks ago (k = 0..44), where bits before reset or clear count as 0. The value lies in 0..1024, and 45 consecutive ones give 1024.
- R4: `valid_o` is 0 until 45 bits have been sampled since the last reset or clear. It is 1 from the clock edge that samples the 45th bit onward, until the next clear or reset.
- R5: When `clr_i` is high at a clock edge, `bit_i` is not sampled. After that edge, `sample_o` is 0 and `valid_o` is 0, and no bit sampled before the clear contributes to any later sample.
- R6: A bit presented on `bit_i` is reflected in `sample_o` immediately after the edge that samples it, with weight 1. Bits sampled more than 44 clocks ago contribute nothing.
- R7: Between two consecutive clocks without a clear, `sample_o` changes by at most 32 in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of history and sample |
| bit_i | input | 1 | Converter bitstream, one bit per clock |
| sample_o | output | 11 | Filtered sample, 0..1024 |
| valid_o | output | 1 | History completely filled since reset or clear |

## Verification
The window length and weights are fixed in the package, so the bench builds the block at its defaults: 45 taps, an 11-bit sample and a 7-bit signed correction. Because the window is this short, a single impulse walks through every weight, and a sweep of two-impulse spacings from 1 to 45 covers every pair of slope runs that can overlap in the correction sum. Long runs of ones, alternating patterns and a pseudo-random stream then exercise the full range, the slew limit and the exactness of the incremental sum against an arithmetic model.

// File: rtl/tukey_bsf_pkg.sv
package tukey_bsf_pkg;
  localparam int TAPS  = 45;
  localparam int EDGE  = 13;                   // last tap of the rising taper
  localparam int PEAK  = 32;
  localparam int FALL0 = TAPS - 1 - EDGE;      // first tap where mirroring applies
  localparam int NGRP  = 9;                    // constant-slope runs
  localparam int DW    = $clog2(PEAK) + 2;     // signed per-clock correction

  function automatic int coef(int k);
    int m;
    if (k < 0 || k >= TAPS) return 0;
    m = (k > FALL0) ? TAPS - 1 - k : k;
    case (m)
      0: return 1;   1: return 3;   2: return 5;   3: return 7;
      4: return 10;  5: return 13;  6: return 16;  7: return 19;
      8: return 22;  9: return 25;  10: return 27; 11: return 29;
      12: return 31;
      default: return PEAK;
    endcase
  endfunction

  function automatic int coef_total();
    int s = 0;
    for (int k = 0; k < TAPS; k++) s += coef(k);
    return s;
  endfunction

  localparam int TOTAL = coef_total();
  localparam int SUM_W = $clog2(TOTAL + 1);
  localparam int CW    = $clog2(TAPS + 1);

  // slope run g covers history taps [lo, lo+len-1]; weight = w(k+1)-w(k)
  function automatic int grp_lo(int g);
    case (g)
      0: return 0;  1: return 3;  2: return 9;  3: return 12;
      4: return 31; 5: return 32; 6: return 35; 7: return 41;
      default: return 44;
    endcase
  endfunction

  function automatic int grp_len(int g);
    case (g)
      1, 6: return 6;
      3, 4, 8: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int grp_wt(int g);
    case (g)
      0, 2: return 2;
      1: return 3;
      3: return 1;
      4: return -1;
      5, 7: return -2;
      6: return -3;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/tukey_bsf_hist.sv
module tukey_bsf_hist
  import tukey_bsf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            bit_i,
  output logic [TAPS-1:0] hist_o
);
  logic [TAPS-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_q <= '0;
    else if (clr_i) hist_q <= '0;
    else            hist_q <= {hist_q[TAPS-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tukey_bsf_slope.sv
module tukey_bsf_slope
  import tukey_bsf_pkg::*;
(
  input  logic                 bit_i,
  input  logic [TAPS-1:0]      hist_i,
  output logic signed [DW-1:0] delta_o
);
  localparam int CNT_W = $clog2(TAPS + 1);

  logic signed [DW-1:0] part [NGRP+1];

  assign part[0] = {{(DW-1){1'b0}}, bit_i};

  for (genvar g = 0; g < NGRP; g++) begin : g_run
    localparam int LO = grp_lo(g);
    localparam int HI = LO + grp_len(g) - 1;
    localparam int WT = grp_wt(g);

    logic [CNT_W-1:0]     ones;
    logic signed [DW-1:0] term;

    always_comb begin
      ones = '0;
      for (int k = 0; k < TAPS; k++)
        if (k >= LO && k <= HI) ones = ones + CNT_W'(hist_i[k]);
    end

    assign term        = DW'(WT * int'(ones));
    assign part[g + 1] = part[g] + term;
  end

  assign delta_o = part[NGRP];
endmodule

// File: rtl/tukey_bsf_acc.sv
module tukey_bsf_acc
  import tukey_bsf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic signed [DW-1:0] delta_i,
  output logic [SUM_W-1:0]     sum_o
);
  logic [SUM_W-1:0] sum_q;

  // true result is always in range, so modular add at SUM_W is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else            sum_q <= sum_q + SUM_W'(delta_i);
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/tukey_bsf_fill.sv
module tukey_bsf_fill
  import tukey_bsf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic full_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (cnt_q != CW'(TAPS))   cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == CW'(TAPS));
endmodule

// File: rtl/tukey_bitstream_filter.sv
module tukey_bitstream_filter
  import tukey_bsf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             bit_i,
  output logic [SUM_W-1:0] sample_o,
  output logic             valid_o
);
  logic [TAPS-1:0]      hist_q;
  logic signed [DW-1:0] delta;

  tukey_bsf_hist u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .bit_i  (bit_i),
    .hist_o (hist_q)
  );

  tukey_bsf_slope u_slope (
    .bit_i   (bit_i),
    .hist_i  (hist_q),
    .delta_o (delta)
  );

  tukey_bsf_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .delta_i (delta),
    .sum_o   (sample_o)
  );

  tukey_bsf_fill u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .full_o (valid_o)
  );
endmodule

// File: rtl/tukey_bitstream_filter_chk.sv
module tukey_bitstream_filter_chk
  import tukey_bsf_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic [TAPS-1:0]  hist_i,
  input logic [SUM_W-1:0] sample_i,
  input logic             valid_i
);
  int            direct;
  logic [CW-1:0] seen_q;

  always_comb begin
    direct = 0;
    for (int k = 0; k < TAPS; k++)
      if (hist_i[k]) direct += coef(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 seen_q <= '0;
    else if (clr_i)              seen_q <= '0;
    else if (seen_q != CW'(TAPS)) seen_q <= seen_q + 1'b1;
  end

  assert_exact_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sample_i) == direct);

  assert_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sample_i) <= TOTAL);

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sample_i == '0) && !valid_i);

  assert_valid_early_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q != CW'(TAPS)) |-> !valid_i);

  assert_valid_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clr_i) |=> valid_i);

  assert_valid_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> (seen_q == CW'(TAPS)));

  assert_slew_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((int'(sample_i) - int'($past(sample_i)) <= PEAK) &&
                (int'(sample_i) - int'($past(sample_i)) >= -PEAK)));
endmodule

bind tukey_bitstream_filter tukey_bitstream_filter_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .hist_i   (hist_q),
  .sample_i (sample_o),
  .valid_i  (valid_o)
);

// File: tb/tukey_bitstream_filter_test.sv
`timescale 1ns/1ps
module tukey_bitstream_filter_test;
  localparam int N = 45;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        bit_i = 1'b0;
  logic [10:0] sample_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int rise_tab [14] = '{1, 3, 5, 7, 10, 13, 16, 19, 22, 25, 27, 29, 31, 32};
  bit hist_m [N];
  int seen_m = 0;
  int prev_s = 0;
  bit prev_clr = 1'b1;

  always #2 clk_i = ~clk_i;

  tukey_bitstream_filter uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .bit_i    (bit_i),
    .sample_o (sample_o),
    .valid_o  (valid_o)
  );

  function automatic int wref(int k);
    if (k < 0 || k > 44) return 0;
    if (k <= 13) return rise_tab[k];
    if (k <= 31) return 32;
    return rise_tab[44 - k];
  endfunction

  function automatic int expect_sum();
    int s = 0;
    for (int k = 0; k < N; k++) if (hist_m[k]) s += wref(k);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < N; k++) hist_m[k] = 1'b0;
    seen_m = 0;
  endtask

  // drive one clock, update model at the edge, compare at the falling edge
  task automatic cyc(input bit b, input bit c);
    int e;
    int d;
    bit_i = b;
    clr_i = c;
    @(posedge clk_i);
    if (c) model_clear();
    else begin
      for (int k = N - 1; k > 0; k--) hist_m[k] = hist_m[k - 1];
      hist_m[0] = b;
      if (seen_m < N) seen_m++;
    end
    @(negedge clk_i);
    e = expect_sum();
    chk(int'(sample_o) == e, "R3 sample", int'(sample_o), e);
    chk(valid_o == (seen_m == N), "R4 valid", int'(valid_o), int'(seen_m == N));
    if (!c) begin
      d = int'(sample_o) - prev_s;
      chk(d <= 32 && d >= -32, "R7 slew", d, 0);
    end
    prev_s = int'(sample_o);
    prev_clr = c;
  endtask

  initial begin
    logic [15:0] lfsr;
    model_clear();
    repeat (3) @(negedge clk_i);
    chk(sample_o == 0, "R1 sample in reset", int'(sample_o), 0);
    chk(valid_o == 0, "R1 valid in reset", int'(valid_o), 0);
    rst_ni = 1'b1;

    // R6/R2: impulse walks through every weight
    cyc(1'b1, 1'b0);
    chk(int'(sample_o) == 1, "R6 newest bit weight", int'(sample_o), 1);
    for (int k = 1; k <= 50; k++) begin
      cyc(1'b0, 1'b0);
      chk(int'(sample_o) == wref(k), "R2 impulse weight", int'(sample_o), wref(k));
      if (k == 44) chk(valid_o == 1'b1, "R4 valid after 45 bits", int'(valid_o), 1);
      if (k == 43) chk(valid_o == 1'b0, "R4 not valid at 44 bits", int'(valid_o), 0);
      if (k == 45) chk(int'(sample_o) == 0, "R6 aged out", int'(sample_o), 0);
    end

    // R3: full scale
    for (int k = 0; k < 50; k++) cyc(1'b1, 1'b0);
    chk(int'(sample_o) == 1024, "R3 full scale", int'(sample_o), 1024);

    // R5: clear with ones on the input
    cyc(1'b1, 1'b1);
    chk(int'(sample_o) == 0, "R5 sample cleared", int'(sample_o), 0);
    chk(valid_o == 1'b0, "R5 valid cleared", int'(valid_o), 0);
    for (int k = 0; k < 50; k++) cyc(1'b0, 1'b0);
    chk(int'(sample_o) == 0, "R5 history gone", int'(sample_o), 0);

    // R2/R3: every two-impulse spacing
    for (int s = 1; s <= 45; s++) begin
      cyc(1'b0, 1'b1);
      cyc(1'b1, 1'b0);
      for (int k = 1; k < s; k++) cyc(1'b0, 1'b0);
      cyc(1'b1, 1'b0);
      for (int k = 0; k < 46; k++) cyc(1'b0, 1'b0);
      chk(int'(sample_o) == 0, "R6 pair aged out", int'(sample_o), 0);
    end

    // R3: alternating and period-3 patterns
    for (int k = 0; k < 120; k++) cyc(k[0], 1'b0);
    for (int k = 0; k < 120; k++) cyc((k % 3) == 0, 1'b0);

    // R3/R7: pseudo-random stream with varying density, occasional clears
    lfsr = 16'hace1;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (k % 997 == 500) cyc(1'b0, 1'b1);
      else if (k < 1500) cyc(lfsr[0], 1'b0);
      else if (k < 2800) cyc(lfsr[0] | lfsr[3], 1'b0);
      else cyc(lfsr[0] & lfsr[5], 1'b0);
    end

    // R1: asynchronous reset mid-stream
    for (int k = 0; k < 30; k++) cyc(1'b1, 1'b0);
    #1 rst_ni = 1'b0;
    #0.5;
    chk(sample_o == 0, "R1 sample after async reset", int'(sample_o), 0);
    chk(valid_o == 0, "R1 valid after async reset", int'(valid_o), 0);
    model_clear();
    prev_s = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < 60; k++) cyc(1'b1, 1'b0);
    chk(int'(sample_o) == 1024, "R3 full scale after reset", int'(sample_o), 1024);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule